// File: doc/BRIEF.md
# Three-Lane RGB666 Panel Link Transmitter

The block drives a 1280x800 flat panel over a three-lane serial link with a forwarded clock lane. A raster timing generator in the pixel clock domain walks a fixed line and frame grid and derives horizontal sync, vertical sync and data-enable. For every pixel clock, an 18-bit colour word (six bits each of red, green and blue) is taken either from the pixel input or from an internal vertical colour bar generator. It is then merged with the three timing flags and split into three 7-bit lane words.

A bit clock running at exactly seven times the pixel rate, phase-locked to it, shifts each lane word out one bit per bit clock. A fourth lane repeats a fixed 7-bit framing pattern once per pixel, so a receiver can find word boundaries and recover the pixel clock. The line length, blanking widths and bar width are parameters. The defaults give a 1400-clock line and an 833-line frame, which is 60 frames per second at a 70 MHz pixel clock.

Top module: `panel_link_tx`

## Requirements
- R1: While `rst_n` is low, all four serial outputs are 0. The first pixel word is sampled on the third rising `pix_clk` edge after `rst_n` rises, and that word is the first active pixel of line 0.
- R2: Every line lasts H_ACT+H_FP+H_SW+H_BP pixel clocks (default 1280+4+4+112 = 1400). Horizontal sync is high for H_SW clocks, starting H_FP clocks after the last active pixel. This holds on every line, including vertical blanking lines.
- R3: Every frame lasts V_ACT+V_FP+V_SW+V_BP lines (default 800+1+2+30 = 833). Vertical sync is high for V_SW whole lines, starting V_FP lines after the last active line, and it changes only at a line boundary.
- R4: Data-enable is high exactly for the first H_ACT pixels of each of the first V_ACT lines, and low otherwise.
- R5: Whenever data-enable is low, all 18 colour bits sent are 0, whatever `pat_sel` and `pix_rgb` hold.
- R6: Lane words, first-sent bit listed first: lane 0 = G0,R5,R4,R3,R2,R1,R0. Lane 1 = B1,B0,G5,G4,G3,G2,G1. Lane 2 = DE,VS,HS,B5,B4,B3,B2. `pix_rgb` is {R[5:0],G[5:0],B[5:0]} from bit 17 down.
- R7: `ser_clk` repeats the 7-bit pattern 1,1,0,0,0,1,1 (first bit first) with no gap, so a new word on all lanes starts every 7 bit clocks.
- R8: When `pat_sel` is high during an active pixel at column h, bar index b = min(h / BAR_W, 7) and c = 7 - b. R is all ones if c bit 2 is set, G is all ones if c bit 1 is set, B is all ones if c bit 0 is set; each is zero otherwise.
- R9: When `pat_sel` is low during an active pixel, the colour sent is the `pix_rgb` value present at the pixel clock edge that samples that raster position.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| pix_clk | input | 1 | Pixel clock; must toggle continuously |
| bit_clk | input | 1 | Serial bit clock, 7x `pix_clk`, phase-locked |
| rst_n | input | 1 | Asynchronous active-low reset |
| pix_rgb | input | 18 | Pixel colour {R,G,B}, 6 bits each |
| pat_sel | input | 1 | 1 selects the colour bar pattern |
| ser_lane0 | output | 1 | Serial data lane 0 |
| ser_lane1 | output | 1 | Serial data lane 1 |
| ser_lane2 | output | 1 | Serial data lane 2 (carries sync and enable) |
| ser_clk | output | 1 | Forwarded clock lane pattern |

## Verification
The bar generator and the blanking zero-force both claim the colour slots in the same cycle whenever `pat_sel` is high outside the active window. The third frame of the run holds `pat_sel` high through all of its blanking, and the second frame toggles it at random. Each recovered word is judged against a raster model in the bench: blank positions must carry zero colour, and active positions must carry bars or the driven input. Horizontal sync pulses that fall inside vertical sync lines are judged in the same way, since both flags share lane 2 in one word.

// File: rtl/panel_link_pkg.sv
package panel_link_pkg;

  localparam int unsigned LANE_W    = 7;
  localparam int unsigned COL_W     = 6;
  localparam int unsigned DATA_LANES = 3;
  localparam int unsigned NUM_LANES = DATA_LANES + 1;
  localparam int unsigned WORD_W    = DATA_LANES * LANE_W;

  localparam logic [LANE_W-1:0] FRAME_PAT = 7'b1100011;

  typedef logic [LANE_W-1:0] lane_t;

  typedef struct packed {
    logic [COL_W-1:0] r;
    logic [COL_W-1:0] g;
    logic [COL_W-1:0] b;
  } rgb_t;

  typedef struct packed {
    logic de;
    logic vs;
    logic hs;
  } sync_t;

  // bit 6 of each lane word leaves the block first
  function automatic logic [WORD_W-1:0] pack_lanes(input rgb_t p, input sync_t s);
    lane_t w0, w1, w2;
    w0 = {p.g[0], p.r};
    w1 = {p.b[1:0], p.g[5:1]};
    w2 = {s.de, s.vs, s.hs, p.b[5:2]};
    return {w2, w1, w0};
  endfunction

endpackage

// File: rtl/plk_rst_sync.sv
module plk_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_n_sync
);
  logic [1:0] stg_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) stg_q <= 2'b00;
    else        stg_q <= {stg_q[0], 1'b1};
  end

  assign rst_n_sync = stg_q[1];
endmodule

// File: rtl/plk_raster.sv
module plk_raster
  import panel_link_pkg::*;
#(
  parameter int unsigned H_ACT = 1280,
  parameter int unsigned H_FP  = 4,
  parameter int unsigned H_SW  = 4,
  parameter int unsigned H_BP  = 112,
  parameter int unsigned V_ACT = 800,
  parameter int unsigned V_FP  = 1,
  parameter int unsigned V_SW  = 2,
  parameter int unsigned V_BP  = 30,
  parameter int unsigned BAR_W = 160
) (
  input  logic       clk,
  input  logic       rst_n,
  output sync_t      sync_o,
  output logic [2:0] bar_o
);
  localparam int unsigned H_TOT = H_ACT + H_FP + H_SW + H_BP;
  localparam int unsigned V_TOT = V_ACT + V_FP + V_SW + V_BP;
  localparam int unsigned HW = $clog2(H_TOT);
  localparam int unsigned VW = $clog2(V_TOT);
  localparam int unsigned CW = (BAR_W > 1) ? $clog2(BAR_W) : 1;

  localparam logic [HW-1:0] H_LAST  = HW'(H_TOT - 1);
  localparam logic [VW-1:0] V_LAST  = VW'(V_TOT - 1);
  localparam logic [HW-1:0] H_ACT_L = HW'(H_ACT);
  localparam logic [VW-1:0] V_ACT_L = VW'(V_ACT);
  localparam logic [HW-1:0] HS_BEG  = HW'(H_ACT + H_FP);
  localparam logic [HW-1:0] HS_END  = HW'(H_ACT + H_FP + H_SW);
  localparam logic [VW-1:0] VS_BEG  = VW'(V_ACT + V_FP);
  localparam logic [VW-1:0] VS_END  = VW'(V_ACT + V_FP + V_SW);
  localparam logic [CW-1:0] COL_LAST = CW'(BAR_W - 1);

  logic [HW-1:0] h_q, h_d;
  logic [VW-1:0] v_q, v_d;
  logic [CW-1:0] col_q, col_d;
  logic [2:0]    bar_q, bar_d;

  always_comb begin
    h_d   = h_q + 1'b1;
    v_d   = v_q;
    col_d = col_q + 1'b1;
    bar_d = bar_q;
    if (col_q == COL_LAST) begin
      col_d = '0;
      if (bar_q != 3'd7) bar_d = bar_q + 3'd1;
    end
    if (h_q == H_LAST) begin
      h_d   = '0;
      col_d = '0;
      bar_d = '0;
      v_d   = (v_q == V_LAST) ? '0 : v_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      h_q   <= '0;
      v_q   <= '0;
      col_q <= '0;
      bar_q <= '0;
    end else begin
      h_q   <= h_d;
      v_q   <= v_d;
      col_q <= col_d;
      bar_q <= bar_d;
    end
  end

  always_comb begin
    sync_o.hs = (h_q >= HS_BEG) && (h_q < HS_END);
    sync_o.vs = (v_q >= VS_BEG) && (v_q < VS_END);
    sync_o.de = (h_q < H_ACT_L) && (v_q < V_ACT_L);
  end

  assign bar_o = bar_q;

  assert_line_wrap_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (h_q == H_LAST) |=> (h_q == '0));

  assert_line_step_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (h_q != H_LAST) |=> (h_q == $past(h_q) + 1'b1));

  assert_vs_on_line_edge_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (h_q != '0) |-> $stable(sync_o.vs));

  assert_frame_wrap_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (v_q == V_LAST && h_q == H_LAST) |=> (v_q == '0));
endmodule

// File: rtl/plk_mapper.sv
module plk_mapper
  import panel_link_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  rgb_t              pix_i,
  input  logic              pat_i,
  input  sync_t             sync_i,
  input  logic [2:0]        bar_i,
  output logic [WORD_W-1:0] word_o,
  output logic              tog_o
);
  logic [2:0]        shade;
  rgb_t              bar_rgb, src;
  logic [WORD_W-1:0] word_d, word_q;
  logic              tog_q;

  always_comb begin
    shade   = 3'd7 - bar_i;
    bar_rgb = '{r: {COL_W{shade[2]}}, g: {COL_W{shade[1]}}, b: {COL_W{shade[0]}}};
    src     = pat_i ? bar_rgb : pix_i;
    if (!sync_i.de) src = '0;
    word_d  = pack_lanes(src, sync_i);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      word_q <= '0;
      tog_q  <= 1'b0;
    end else begin
      word_q <= word_d;
      tog_q  <= ~tog_q;
    end
  end

  assign word_o = word_q;
  assign tog_o  = tog_q;

  // colour occupies word bits 17:0, enable flag sits at bit 20
  assert_blank_zero_R5: assert property (@(posedge clk) disable iff (!rst_n)
    !word_q[WORD_W-1] |-> (word_q[17:0] == '0));
endmodule

// File: rtl/plk_serializer.sv
module plk_serializer
  import panel_link_pkg::*;
(
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 tog_i,
  input  logic [WORD_W-1:0]    word_i,
  output logic [NUM_LANES-1:0] ser_o
);
  logic [2:0] tsync_q;
  logic       load;
  lane_t      src [NUM_LANES];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) tsync_q <= '0;
    else        tsync_q <= {tsync_q[1:0], tog_i};
  end

  assign load = tsync_q[1] ^ tsync_q[2];

  for (genvar d = 0; d < DATA_LANES; d++) begin : g_src
    assign src[d] = word_i[d*LANE_W +: LANE_W];
  end
  assign src[DATA_LANES] = FRAME_PAT;

  for (genvar i = 0; i < NUM_LANES; i++) begin : g_lane
    lane_t sh_q, sh_d;
    always_comb sh_d = load ? src[i] : {sh_q[LANE_W-2:0], 1'b0};
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) sh_q <= '0;
      else        sh_q <= sh_d;
    end
    assign ser_o[i] = sh_q[LANE_W-1];
  end

  logic [2:0] gap_q;
  logic       seen_q;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      gap_q  <= '0;
      seen_q <= 1'b0;
    end else if (load) begin
      gap_q  <= '0;
      seen_q <= 1'b1;
    end else if (gap_q != 3'd7) begin
      gap_q  <= gap_q + 3'd1;
    end
  end

  assert_load_period_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (load && seen_q) |-> (gap_q == 3'd6));

  assert_no_stall_R7: assert property (@(posedge clk) disable iff (!rst_n)
    seen_q |-> (gap_q != 3'd7));
endmodule

// File: rtl/panel_link_tx.sv
module panel_link_tx
  import panel_link_pkg::*;
#(
  parameter int unsigned H_ACT = 1280,
  parameter int unsigned H_FP  = 4,
  parameter int unsigned H_SW  = 4,
  parameter int unsigned H_BP  = 112,
  parameter int unsigned V_ACT = 800,
  parameter int unsigned V_FP  = 1,
  parameter int unsigned V_SW  = 2,
  parameter int unsigned V_BP  = 30,
  parameter int unsigned BAR_W = 160
) (
  input  logic        pix_clk,
  input  logic        bit_clk,
  input  logic        rst_n,
  input  logic [17:0] pix_rgb,
  input  logic        pat_sel,
  output logic        ser_lane0,
  output logic        ser_lane1,
  output logic        ser_lane2,
  output logic        ser_clk
);
  logic                 prst_n, brst_n;
  sync_t                sync;
  logic [2:0]           bar;
  logic [WORD_W-1:0]    word;
  logic                 tog;
  logic [NUM_LANES-1:0] ser;

  plk_rst_sync u_prst (.clk(pix_clk), .rst_n(rst_n), .rst_n_sync(prst_n));
  plk_rst_sync u_brst (.clk(bit_clk), .rst_n(rst_n), .rst_n_sync(brst_n));

  plk_raster #(
    .H_ACT(H_ACT), .H_FP(H_FP), .H_SW(H_SW), .H_BP(H_BP),
    .V_ACT(V_ACT), .V_FP(V_FP), .V_SW(V_SW), .V_BP(V_BP),
    .BAR_W(BAR_W)
  ) u_raster (
    .clk(pix_clk), .rst_n(prst_n), .sync_o(sync), .bar_o(bar)
  );

  plk_mapper u_map (
    .clk(pix_clk), .rst_n(prst_n), .pix_i(rgb_t'(pix_rgb)), .pat_i(pat_sel),
    .sync_i(sync), .bar_i(bar), .word_o(word), .tog_o(tog)
  );

  plk_serializer u_ser (
    .clk(bit_clk), .rst_n(brst_n), .tog_i(tog), .word_i(word), .ser_o(ser)
  );

  assign ser_lane0 = ser[0];
  assign ser_lane1 = ser[1];
  assign ser_lane2 = ser[2];
  assign ser_clk   = ser[3];
endmodule

// File: tb/sim_panel_link_tx.sv
module sim_panel_link_tx;
  localparam int unsigned H_ACT = 16, H_FP = 2, H_SW = 3, H_BP = 4;
  localparam int unsigned V_ACT = 6, V_FP = 1, V_SW = 2, V_BP = 3;
  localparam int unsigned BAR_W = 2;
  localparam int unsigned HT = H_ACT + H_FP + H_SW + H_BP;
  localparam int unsigned VT = V_ACT + V_FP + V_SW + V_BP;
  localparam int unsigned FRAME = HT * VT;
  localparam int unsigned WORDS = 3 * FRAME;
  localparam int unsigned DEPTH = 2048;

  logic bit_clk = 1'b0, pix_clk = 1'b0, rst_n = 1'b0;
  logic [17:0] pix_rgb = '0;
  logic pat_sel = 1'b0;
  logic ser_lane0, ser_lane1, ser_lane2, ser_clk;

  panel_link_tx #(
    .H_ACT(H_ACT), .H_FP(H_FP), .H_SW(H_SW), .H_BP(H_BP),
    .V_ACT(V_ACT), .V_FP(V_FP), .V_SW(V_SW), .V_BP(V_BP), .BAR_W(BAR_W)
  ) u0 (
    .pix_clk(pix_clk), .bit_clk(bit_clk), .rst_n(rst_n), .pix_rgb(pix_rgb),
    .pat_sel(pat_sel), .ser_lane0(ser_lane0), .ser_lane1(ser_lane1),
    .ser_lane2(ser_lane2), .ser_clk(ser_clk)
  );

  always #5 bit_clk = ~bit_clk;

  int unsigned ph = 0;
  always @(negedge bit_clk) begin
    if (ph == 0) pix_clk = 1'b1;
    else if (ph == 3) pix_clk = 1'b0;
    ph = (ph == 6) ? 0 : ph + 1;
  end

  int unsigned checks = 0, errors = 0;
  logic [17:0] drv_rgb [DEPTH];
  bit          drv_pat [DEPTH];
  bit          done = 1'b0;

  task automatic chk(input bit ok, input string tag, input int unsigned act, input int unsigned exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic logic [17:0] bar_colour(input int unsigned h);
    int unsigned b = h / BAR_W;
    logic [2:0] c;
    if (b > 7) b = 7;
    c = 3'(7 - b);
    return {{6{c[2]}}, {6{c[1]}}, {6{c[0]}}};
  endfunction

  task automatic judge(input int unsigned k, input logic [6:0] w0, input logic [6:0] w1,
                       input logic [6:0] w2, input int unsigned gap);
    int unsigned e = k + 2;
    int unsigned h = k % HT;
    int unsigned v = (k / HT) % VT;
    bit ede = (h < H_ACT) && (v < V_ACT);
    bit ehs = (h >= H_ACT + H_FP) && (h < H_ACT + H_FP + H_SW);
    bit evs = (v >= V_ACT + V_FP) && (v < V_ACT + V_FP + V_SW);
    logic [17:0] erg, grg;
    logic [5:0] er, eg, eb;
    logic [20:0] eword;
    string ctag;
    if (!ede)            begin erg = '0;             ctag = "R5"; end
    else if (drv_pat[e]) begin erg = bar_colour(h);  ctag = "R8"; end
    else                 begin erg = drv_rgb[e];     ctag = "R9"; end
    grg = {w0[5:0], w1[4:0], w0[6], w2[3:0], w1[6:5]};
    chk(w2[6] == ede, "R4 enable", w2[6], ede);
    chk(w2[4] == ehs, "R2 hsync", w2[4], ehs);
    chk(w2[5] == evs, "R3 vsync", w2[5], evs);
    chk(grg == erg, ctag, grg, erg);
    er = erg[17:12]; eg = erg[11:6]; eb = erg[5:0];
    eword = {ede, evs, ehs, eb[5:2], eb[1:0], eg[5:1], eg[0], er};
    chk({w2, w1, w0} == eword, "R6 lanes", {w2, w1, w0}, eword);
    if (k == 0) chk(ede && !ehs && !evs, "R1 first word", {w2[6], w2[5], w2[4]}, 3'b100);
    if (k > 0)  chk(gap == 7, "R7 word spacing", gap, 7);
  endtask

  logic [6:0] hs0 = '0, hs1 = '0, hs2 = '0, hsc = '0;
  int unsigned bitn = 0, last_bit = 0, kw = 0;
  always @(negedge bit_clk) begin
    if (rst_n && !done) begin
      hs0 = {hs0[5:0], ser_lane0};
      hs1 = {hs1[5:0], ser_lane1};
      hs2 = {hs2[5:0], ser_lane2};
      hsc = {hsc[5:0], ser_clk};
      bitn++;
      if (hsc == 7'b1100011) begin
        judge(kw, hs0, hs1, hs2, bitn - last_bit);
        last_bit = bitn;
        kw++;
        if (kw == WORDS) done = 1'b1;
      end
    end
  end

  // stimulus: frame 0 live input only, frame 1 random mix, frame 2 bars throughout
  initial begin
    void'($urandom(32'd4711));
    for (int i = 0; i < DEPTH; i++) begin
      int unsigned f = (i < 2) ? 0 : (i - 2) / FRAME;
      drv_rgb[i] = 18'($urandom);
      if (i % 37 == 0) drv_rgb[i] = 18'h3FFFF;
      if (i % 41 == 0) drv_rgb[i] = 18'h00000;
      drv_pat[i] = (f == 0) ? 1'b0 : (f == 1) ? ($urandom % 3 == 0) : 1'b1;
    end
    pix_rgb = 18'h3FFFF;
    pat_sel = 1'b1;
    for (int i = 0; i < 5; i++) begin
      repeat (3) @(negedge bit_clk);
      chk({ser_lane0, ser_lane1, ser_lane2, ser_clk} == 4'b0000, "R1 reset quiet",
          {ser_lane0, ser_lane1, ser_lane2, ser_clk}, 0);
    end
    @(negedge pix_clk);
    rst_n   = 1'b1;
    pix_rgb = drv_rgb[0];
    pat_sel = drv_pat[0];
    for (int e = 1; e < DEPTH; e++) begin
      @(negedge pix_clk);
      pix_rgb = drv_rgb[e];
      pat_sel = drv_pat[e];
    end
  end

  initial begin
    bit timeout = 1'b0;
    fork
      wait (done);
      begin
        repeat (20000) @(posedge bit_clk);
        timeout = 1'b1;
      end
    join_any
    disable fork;
    if (timeout) chk(1'b0, "R7 watchdog words seen", kw, WORDS);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule